// File: doc/BRIEF.md
# Lamp Ballast Mode Sequencer

This block is the mode controller of an electronic fluorescent lamp ballast. It takes comparator results that are already digital and decides which of five modes the ballast is in: lockout, preheat, ignition, run and fault. From the mode it drives the enables of the half-bridge and PFC gate drivers, commands that discharge the preheat timer node and the oscillator control node, a supply-discharge command, the PFC loop gain select, and the enables of the three protections (over-current counter, end-of-life window and bus undervoltage).

All comparator flags are brought into the clock domain through a two-flop synchronizer before the state machine uses them. The preheat timer flag advances the sequence on its rising edges only. Each protection acts only in the modes where it is enabled. Once in fault, the block stays there until the supply collapses or the lamp is pulled out. It starts again only after the lamp is put back in, which shows as the shutdown input going high and then low.

Top module: `ballast_seq`

## Requirements
- R1: An asynchronous reset puts the block in lockout with all three gate enables low and both node discharges high; `mode_o` encodes lockout 0, preheat 1, ignition 2, run 3, fault 4.
- R2: Lockout moves to preheat only when the supply is above its upper threshold and the shutdown input has been seen above its high threshold and then below its low threshold. In preheat the three gate enables are high.
- R3: In preheat a rising edge of the timer flag moves the block to ignition. In ignition the next rising edge moves it to run. A timer flag held high counts as one edge.
- R4: PFC gain select is high in preheat and ignition and low in run.
- R5: The over-current counter enable is high in preheat and run and low in ignition. The end-of-life and bus-undervoltage enables are high only in run.
- R6: In run, either end-of-life window flag (above upper or below lower) moves the block to fault. In ignition both flags are ignored.
- R7: The over-current fault flag moves preheat or run to fault and is ignored in ignition.
- R8: The bus-undervoltage flag in run sets a latched shutdown: supply discharge high and all gate enables low. The mode stays run and the latch holds until lockout. The flag has no effect in other modes.
- R9: In fault all gate enables are low and both node discharges are high. Fault is left only for lockout, when the supply drops below its lower threshold or the shutdown input rises above its high threshold.
- R10: From preheat, ignition or run, the supply below its lower threshold or the shutdown input above its high threshold moves the block to lockout.
- R11: A flag change reaches `mode_o` on the third rising clock edge after it is applied and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_above_up | input | 1 | Supply above upper lockout threshold |
| vcc_above_low | input | 1 | Supply above lower lockout threshold |
| tmr_cross | input | 1 | Preheat timer above two thirds of supply |
| sd_above_hi | input | 1 | Shutdown input above high threshold |
| sd_below_lo | input | 1 | Shutdown input below low threshold |
| eol_over | input | 1 | End-of-life input above window |
| eol_under | input | 1 | End-of-life input below window |
| bus_uv | input | 1 | DC bus sense below undervoltage threshold |
| oc_fault | input | 1 | Over-current counter has expired |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| pfc_en | output | 1 | PFC gate enable |
| tmr_dis | output | 1 | Discharge preheat timer node |
| osc_dis | output | 1 | Discharge oscillator control node |
| vcc_dis | output | 1 | Discharge supply |
| pfc_gain_hi | output | 1 | High PFC loop gain |
| oc_cnt_en | output | 1 | Over-current counter enable |
| eol_chk_en | output | 1 | End-of-life window enable |
| busuv_chk_en | output | 1 | Bus undervoltage enable |
| mode_o | output | 3 | Current mode |

## Verification
The sequence is tried three ways. A startup without the lamp-insertion pulse separates correct arming from a bare supply check. A timer flag held high for many cycles separates edge counting from level counting. A clean pulse pair shows the two crossings reaching run. The same fault flags are applied in ignition, preheat and run, so the mode-dependent masking of each protection is seen on its own. The bus-undervoltage latch is checked after its flag clears, and the edge-exact latency test shows whether the synchronizer depth is right.

// File: rtl/ballast_pkg.sv
package ballast_pkg;
    typedef enum logic [2:0] {
        M_UVLO  = 3'd0,
        M_PRE   = 3'd1,
        M_IGN   = 3'd2,
        M_RUN   = 3'd3,
        M_FAULT = 3'd4
    } mode_e;

    localparam int NFLAG     = 9;
    localparam int F_VCC_UP  = 0;
    localparam int F_VCC_OK  = 1;
    localparam int F_TMR     = 2;
    localparam int F_SD_HI   = 3;
    localparam int F_SD_LO   = 4;
    localparam int F_EOL_OVR = 5;
    localparam int F_EOL_UND = 6;
    localparam int F_BUS_UV  = 7;
    localparam int F_OC      = 8;
endpackage

// File: rtl/ballast_sync.sv
module ballast_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q[STAGES-1];
endmodule

// File: rtl/ballast_fsm.sv
module ballast_fsm
    import ballast_pkg::*;
#(
    parameter int RUN_CROSS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] flags,
    output mode_e            mode_o,
    output logic             kill_o
);
    localparam int CW = $clog2(RUN_CROSS + 1);

    typedef struct packed {
        mode_e         mode;
        logic          arm;
        logic          kill;
        logic          tmr_prev;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t st_d, st_q;
    logic rise, drop, eol_bad;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        rise    = flags[F_TMR] && !st_q.tmr_prev;
        drop    = !flags[F_VCC_OK] || flags[F_SD_HI];
        eol_bad = flags[F_EOL_OVR] || flags[F_EOL_UND];
        cnt_inc = st_q.cnt + CW'(1);
        st_d.tmr_prev = flags[F_TMR];

        case (st_q.mode)
            M_UVLO: begin
                st_d.kill = 1'b0;
                st_d.cnt  = '0;
                if (flags[F_SD_HI]) st_d.arm = 1'b1;
                if (st_q.arm && flags[F_SD_LO] && !flags[F_SD_HI] &&
                    flags[F_VCC_UP] && flags[F_VCC_OK]) begin
                    st_d.mode = M_PRE;
                    st_d.arm  = 1'b0;
                end
            end
            M_PRE: begin
                if (drop) begin
                    st_d.mode = M_UVLO;
                    st_d.arm  = 1'b0;
                end else if (flags[F_OC]) begin
                    st_d.mode = M_FAULT;
                end else if (rise) begin
                    st_d.cnt  = cnt_inc;
                    st_d.mode = M_IGN;
                end
            end
            M_IGN: begin
                if (drop) begin
                    st_d.mode = M_UVLO;
                    st_d.arm  = 1'b0;
                end else if (rise) begin
                    st_d.cnt = cnt_inc;
                    if (cnt_inc >= CW'(RUN_CROSS)) st_d.mode = M_RUN;
                end
            end
            M_RUN: begin
                if (drop) begin
                    st_d.mode = M_UVLO;
                    st_d.arm  = 1'b0;
                end else if (eol_bad || flags[F_OC]) begin
                    st_d.mode = M_FAULT;
                end else if (flags[F_BUS_UV]) begin
                    st_d.kill = 1'b1;
                end
            end
            M_FAULT: begin
                if (drop) begin
                    st_d.mode = M_UVLO;
                    st_d.arm  = 1'b0;
                end
            end
            default: st_d.mode = M_UVLO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode     <= M_UVLO;
            st_q.arm      <= 1'b0;
            st_q.kill     <= 1'b0;
            st_q.tmr_prev <= 1'b0;
            st_q.cnt      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign kill_o = st_q.kill;

    // R9
    fault_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode == M_FAULT |=> (st_q.mode == M_FAULT || st_q.mode == M_UVLO));

    // R6
    ign_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode == M_IGN |=> st_q.mode != M_FAULT);

    // R2
    uvlo_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode == M_UVLO |=> (st_q.mode == M_UVLO || st_q.mode == M_PRE));

    // R10
    supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != M_UVLO && !flags[F_VCC_OK]) |=> st_q.mode == M_UVLO);

    // R8
    kill_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.kill && st_q.mode != M_UVLO) |=> st_q.kill);
endmodule

// File: rtl/ballast_drive.sv
module ballast_drive
    import ballast_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  logic  kill,
    output logic  hs_en,
    output logic  ls_en,
    output logic  pfc_en,
    output logic  tmr_dis,
    output logic  osc_dis,
    output logic  vcc_dis,
    output logic  pfc_gain_hi,
    output logic  oc_cnt_en,
    output logic  eol_chk_en,
    output logic  busuv_chk_en
);
    logic gate_on, hold_dis;

    always_comb begin
        gate_on      = (mode == M_PRE || mode == M_IGN || mode == M_RUN) && !kill;
        hold_dis     = (mode == M_UVLO || mode == M_FAULT);
        hs_en        = gate_on;
        ls_en        = gate_on;
        pfc_en       = gate_on;
        tmr_dis      = hold_dis;
        osc_dis      = hold_dis;
        vcc_dis      = kill;
        pfc_gain_hi  = (mode == M_PRE || mode == M_IGN);
        oc_cnt_en    = (mode == M_PRE || mode == M_RUN);
        eol_chk_en   = (mode == M_RUN);
        busuv_chk_en = (mode == M_RUN);
    end

    // R9
    fault_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == M_FAULT |-> (!hs_en && !ls_en && !pfc_en && tmr_dis && osc_dis));

    // R8
    kill_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |-> (!hs_en && !ls_en && !pfc_en && vcc_dis));

    // R5
    ign_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == M_IGN |-> (!oc_cnt_en && !eol_chk_en && pfc_gain_hi));
endmodule

// File: rtl/ballast_seq.sv
module ballast_seq
    import ballast_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RUN_CROSS   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_above_up,
    input  logic       vcc_above_low,
    input  logic       tmr_cross,
    input  logic       sd_above_hi,
    input  logic       sd_below_lo,
    input  logic       eol_over,
    input  logic       eol_under,
    input  logic       bus_uv,
    input  logic       oc_fault,
    output logic       hs_en,
    output logic       ls_en,
    output logic       pfc_en,
    output logic       tmr_dis,
    output logic       osc_dis,
    output logic       vcc_dis,
    output logic       pfc_gain_hi,
    output logic       oc_cnt_en,
    output logic       eol_chk_en,
    output logic       busuv_chk_en,
    output logic [2:0] mode_o
);
    logic [NFLAG-1:0] raw_flags, sync_flags;
    mode_e            mode;
    logic             kill;

    always_comb begin
        raw_flags            = '0;
        raw_flags[F_VCC_UP]  = vcc_above_up;
        raw_flags[F_VCC_OK]  = vcc_above_low;
        raw_flags[F_TMR]     = tmr_cross;
        raw_flags[F_SD_HI]   = sd_above_hi;
        raw_flags[F_SD_LO]   = sd_below_lo;
        raw_flags[F_EOL_OVR] = eol_over;
        raw_flags[F_EOL_UND] = eol_under;
        raw_flags[F_BUS_UV]  = bus_uv;
        raw_flags[F_OC]      = oc_fault;
    end

    ballast_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_flags), .sync_o(sync_flags)
    );

    ballast_fsm #(.RUN_CROSS(RUN_CROSS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .flags(sync_flags), .mode_o(mode), .kill_o(kill)
    );

    ballast_drive u_drive (
        .clk(clk), .rst_n(rst_n), .mode(mode), .kill(kill),
        .hs_en(hs_en), .ls_en(ls_en), .pfc_en(pfc_en),
        .tmr_dis(tmr_dis), .osc_dis(osc_dis), .vcc_dis(vcc_dis),
        .pfc_gain_hi(pfc_gain_hi), .oc_cnt_en(oc_cnt_en),
        .eol_chk_en(eol_chk_en), .busuv_chk_en(busuv_chk_en)
    );

    assign mode_o = mode;
endmodule

// File: tb/tb_ballast_seq.sv
module tb_ballast_seq;
    logic clk = 1'b0, rst_n = 1'b0;
    logic vcc_up, vcc_ok, tmr, sd_hi, sd_lo, eov, eun, buv, ocf;
    logic hs, ls, pfc, tdis, odis, vdis, gain, ocen, eolen, buven;
    logic [2:0] mode;
    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ballast_seq dut (
        .clk(clk), .rst_n(rst_n), .vcc_above_up(vcc_up), .vcc_above_low(vcc_ok),
        .tmr_cross(tmr), .sd_above_hi(sd_hi), .sd_below_lo(sd_lo),
        .eol_over(eov), .eol_under(eun), .bus_uv(buv), .oc_fault(ocf),
        .hs_en(hs), .ls_en(ls), .pfc_en(pfc), .tmr_dis(tdis), .osc_dis(odis),
        .vcc_dis(vdis), .pfc_gain_hi(gain), .oc_cnt_en(ocen),
        .eol_chk_en(eolen), .busuv_chk_en(buven), .mode_o(mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        vcc_up = 0; vcc_ok = 0; tmr = 0; sd_hi = 0; sd_lo = 1;
        eov = 0; eun = 0; buv = 0; ocf = 0;
        rst_n = 0;
        #1;
        // R1 reset state, mode encoding
        chk("R1 mode", mode, 0);
        chk("R1 gates", {hs, ls, pfc}, 3'b000);
        chk("R1 discharges", {tdis, odis}, 2'b11);
        wt(2);
        rst_n = 1;
        wt(1);
    endtask

    task automatic go_pre();
        vcc_up = 1; vcc_ok = 1; sd_hi = 1; sd_lo = 0;
        wt(4);
        sd_hi = 0; sd_lo = 1;
        wt(4);
    endtask

    task automatic go_run();
        go_pre();
        tmr = 1; wt(4); tmr = 0; wt(4); tmr = 1; wt(4);
    endtask

    task automatic t_arm();
        do_reset();
        vcc_up = 1; vcc_ok = 1;
        wt(8);
        chk("R2 no insertion stays lockout", mode, 0);
        sd_hi = 1; sd_lo = 0; wt(4);
        chk("R2 shutdown high stays lockout", mode, 0);
        sd_hi = 0; sd_lo = 1; wt(4);
        chk("R2 preheat after insertion", mode, 1);
        chk("R2 gates on", {hs, ls, pfc}, 3'b111);
        chk("R4 gain high in preheat", gain, 1);
        chk("R5 enables in preheat", {ocen, eolen, buven}, 3'b100);
    endtask

    task automatic t_ramp();
        do_reset();
        go_pre();
        tmr = 1; wt(12);
        chk("R3 held flag counts once", mode, 2);
        chk("R4 gain high in ignition", gain, 1);
        chk("R5 enables in ignition", {ocen, eolen, buven}, 3'b000);
        eov = 1; wt(4);
        chk("R6 window ignored in ignition", mode, 2);
        eov = 0; ocf = 1; wt(4);
        chk("R7 overcurrent ignored in ignition", mode, 2);
        ocf = 0; tmr = 0; wt(4);
        tmr = 1; wt(4);
        chk("R3 second crossing to run", mode, 3);
        chk("R4 gain low in run", gain, 0);
        chk("R5 enables in run", {ocen, eolen, buven}, 3'b111);
    endtask

    task automatic t_eol();
        do_reset();
        go_run();
        eun = 1; wt(4);
        chk("R6 window fault in run", mode, 4);
        chk("R9 gates low in fault", {hs, ls, pfc}, 3'b000);
        chk("R9 discharges in fault", {tdis, odis}, 2'b11);
        eun = 0; wt(4);
        chk("R9 fault holds", mode, 4);
        sd_hi = 1; sd_lo = 0; wt(4);
        chk("R9 lamp removal exits", mode, 0);
        sd_hi = 0; sd_lo = 1; wt(4);
        chk("R2 reinsertion restarts", mode, 1);
    endtask

    task automatic t_oc();
        do_reset();
        go_pre();
        ocf = 1; wt(4);
        chk("R7 overcurrent in preheat", mode, 4);
        ocf = 0; vcc_ok = 0; vcc_up = 0; wt(4);
        chk("R9 supply collapse exits fault", mode, 0);
        do_reset();
        go_run();
        ocf = 1; wt(4);
        chk("R7 overcurrent in run", mode, 4);
    endtask

    task automatic t_busuv();
        do_reset();
        go_pre();
        buv = 1; wt(4);
        chk("R8 ignored in preheat", {mode, vdis, hs}, {3'd1, 1'b0, 1'b1});
        buv = 0; wt(4);
        tmr = 1; wt(4); tmr = 0; wt(4); tmr = 1; wt(4);
        chk("R8 reached run", mode, 3);
        buv = 1; wt(4);
        chk("R8 shutdown latched", {mode, vdis, hs, ls, pfc}, {3'd3, 4'b1000});
        buv = 0; wt(4);
        chk("R8 latch holds", {vdis, hs}, 2'b10);
        vcc_ok = 0; vcc_up = 0; wt(5);
        chk("R8 latch clears in lockout", {mode, vdis}, {3'd0, 1'b0});
    endtask

    task automatic t_drop();
        do_reset();
        go_run();
        sd_hi = 1; sd_lo = 0; wt(4);
        chk("R10 removal from run", mode, 0);
        do_reset();
        go_pre();
        tmr = 1; wt(4);
        vcc_ok = 0; wt(4);
        chk("R10 supply drop from ignition", mode, 0);
    endtask

    task automatic t_latency();
        do_reset();
        go_pre();
        tmr = 1;
        wt(2);
        chk("R11 not before third edge", mode, 1);
        wt(1);
        chk("R11 on third edge", mode, 2);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_arm();
        t_ramp();
        t_eol();
        t_oc();
        t_busuv();
        t_drop();
        t_latency();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule